// File: doc/BRIEF.md
# Frequency Synthesizer Divider Chain with Lock Detection

This block is the digital core of an integer-N frequency synthesizer. A reference divider turns crystal-derived ticks into a comparison strobe. A programmable divider turns oscillator ticks into a divided strobe. A three-state phase/frequency comparator weighs the two strobes and raises pump-up or pump-down requests. The same comparator also drives a lock flag. The oscillator and crystal clocks arrive as single-cycle enable pulses on the system clock, so the whole block runs in one clock domain.

The programmable divider holds a 15-bit ratio N. The oscillator tick rate is four times the comparison rate times N. Inside, the divider uses either a divide-by-2 or a divide-by-4 front stage. It picks that stage from N and the selected step. It then sizes its main counter so that the total division is always 4·N. Changing the front stage therefore never moves the comparison rate.

A test-mode field can force the pump outputs, or route the halved reference or halved divider signal to two band-control test pins. A separate override parks the pump in sink mode and turns the tuning amplifier off.

Top module: `synth_divchain`

## Requirements
- R1: The reference strobe comes once every K reference ticks. With `rs_b`=1, `rs_a`=1 K is 256. With `rs_b`=1, `rs_a`=0 K is 512. With `rs_b`=0 K is 320, whatever `rs_a` is.
- R2: The divided strobe comes once every 4·N oscillator ticks. N is `n_value`, and values below 1024 act as 1024.
- R3: `presc_div4` is 1 when N is at or above the threshold and 0 otherwise. The threshold is 4096 when the step setting is `rs_a`=`rs_b`=1, and 8192 for any other setting.
- R4: The divided-strobe interval stays at 4·N whichever front stage is in use.
- R5: A new N, step setting or front stage takes effect only at the divider's next terminal count. The interval in progress keeps its old length, so no runt cycle appears.
- R6: In normal mode, `pump_up` rises only in the cycle after a reference strobe and `pump_dn` only in the cycle after a divided strobe. The two are never high together, and both clear once both strobes have arrived.
- R7: `lock` rises in the cycle after the 8th consecutive reference strobe that had no over-wide pulse.
- R8: `lock` clears when a single up or down pulse spans 4 reference ticks.
- R9: `test_mode` is decoded as follows:
  - 00x: normal operation.
  - 010: both pump outputs are off.
  - 110: sink only, so `pump_dn`=1.
  - 011: source only, so `pump_up`=1.
  - 100: the halved reference toggles on `band_fm_test`.
  - 101: the halved divider output toggles on `band_v_test`.
  - 111: both pump outputs are off.
  - In every mode except its own, each test pin is 0.
- R10: `os_off`=1 forces `pump_dn`=1, `pump_up`=0 and `amp_off`=1 over any test mode. `pump_high` follows `cp_high`.
- R11: After reset the outputs are as follows:
  - `lock`, `presc_div4`, both pump outputs and both strobes are 0.
  - The reference ratio is 256.
  - The programmed N is 1024.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ref_tick | input | 1 | Crystal reference tick enable |
| osc_tick | input | 1 | Oscillator tick enable |
| n_value | input | 15 | Programmed divider ratio N |
| rs_a | input | 1 | Step select, low bit |
| rs_b | input | 1 | Step select, high bit |
| cp_high | input | 1 | Pump current level request |
| os_off | input | 1 | Tuning amplifier off, pump forced to sink |
| test_mode | input | 3 | Test mode field {T2,T1,T0} |
| ref_strobe | output | 1 | One-cycle comparison strobe from the reference divider |
| div_strobe | output | 1 | One-cycle strobe at the programmable divider terminal count |
| pump_up | output | 1 | Source request to the charge pump |
| pump_dn | output | 1 | Sink request to the charge pump |
| pump_high | output | 1 | High pump current selected |
| amp_off | output | 1 | Tuning amplifier disabled |
| band_fm_test | output | 1 | Halved reference in test mode |
| band_v_test | output | 1 | Halved divider output in test mode |
| presc_div4 | output | 1 | Divide-by-4 front stage active |
| lock | output | 1 | Loop lock flag |

## Verification
A miscounted main counter or a wrong front-stage choice shows up as a divided-strobe interval that differs from 4·N. That difference is visible within one period of the new setting. A wrong terminal-count load shows up as a changed interval in the very period that should still run at the old value. A faulty comparator or width counter shows up in two ways: `lock` fails to rise within eight comparison periods of matched strobes, or it stays high once the periods diverge. Mode decoding is visible on the pump and test pins in the same cycle the field changes.

// File: rtl/synth_pkg.sv
package synth_pkg;

    typedef enum logic [2:0] {
        TM_NORMAL,
        TM_OFF,
        TM_SINK,
        TM_SOURCE,
        TM_REF,
        TM_DIV
    } tmode_t;

    function automatic tmode_t tm_decode(input logic [2:0] t);
        tmode_t m;
        unique casez (t)
            3'b00?:  m = TM_NORMAL;
            3'b010:  m = TM_OFF;
            3'b110:  m = TM_SINK;
            3'b011:  m = TM_SOURCE;
            3'b100:  m = TM_REF;
            3'b101:  m = TM_DIV;
            default: m = TM_OFF;
        endcase
        return m;
    endfunction

    typedef struct packed {
        logic up;
        logic dn;
        logic hi;
        logic amp_off;
        logic fm_test;
        logic v_test;
    } pump_out_t;

endpackage

// File: rtl/synth_ref_div.sv
module synth_ref_div #(
    parameter int R_FINE   = 256,
    parameter int R_MID    = 320,
    parameter int R_COARSE = 512
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic rs_a,
    input  logic rs_b,
    output logic strobe,
    output logic square
);
    localparam int CW = $clog2(R_COARSE) + 1;

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] lim;
        logic          stb;
        logic          sq;
    } rstate_t;

    rstate_t s_d, s_q;
    logic [CW-1:0] sel_lim;

    always_comb begin
        if (rs_b) sel_lim = rs_a ? CW'(R_FINE - 1) : CW'(R_COARSE - 1);
        else      sel_lim = CW'(R_MID - 1);

        s_d     = s_q;
        s_d.stb = 1'b0;
        if (tick) begin
            if (s_q.cnt == s_q.lim) begin
                s_d.cnt = '0;
                s_d.lim = sel_lim;
                s_d.stb = 1'b1;
                s_d.sq  = ~s_q.sq;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.cnt <= '0;
            s_q.lim <= CW'(R_FINE - 1);
            s_q.stb <= 1'b0;
            s_q.sq  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe = s_q.stb;
    assign square = s_q.sq;
endmodule

// File: rtl/synth_prog_div.sv
module synth_prog_div #(
    parameter int N_W     = 15,
    parameter int N_MIN   = 1024,
    parameter int TH_FINE = 4096,
    parameter int TH_WIDE = 8192
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] n_val,
    input  logic           fine_step,
    output logic           strobe,
    output logic           square,
    output logic           div4
);
    localparam int LW = N_W + 1;

    typedef struct packed {
        logic [1:0]    pc;
        logic [LW-1:0] cnt;
        logic [LW-1:0] lim;
        logic          div4;
        logic          stb;
        logic          sq;
    } pstate_t;

    pstate_t s_d, s_q;
    logic [LW-1:0] n_eff;
    logic [LW-1:0] lim_new;
    logic          want4;
    logic          pc_wrap;

    always_comb begin
        n_eff   = (LW'(n_val) < LW'(N_MIN)) ? LW'(N_MIN) : LW'(n_val);
        want4   = n_eff >= (fine_step ? LW'(TH_FINE) : LW'(TH_WIDE));
        lim_new = want4 ? (n_eff - 1'b1) : ({n_eff[LW-2:0], 1'b0} - 1'b1);
        pc_wrap = (s_q.pc == (s_q.div4 ? 2'd3 : 2'd1));

        s_d     = s_q;
        s_d.stb = 1'b0;
        if (tick) begin
            if (pc_wrap) begin
                s_d.pc = '0;
                if (s_q.cnt == s_q.lim) begin
                    s_d.cnt  = '0;
                    s_d.lim  = lim_new;
                    s_d.div4 = want4;
                    s_d.stb  = 1'b1;
                    s_d.sq   = ~s_q.sq;
                end else begin
                    s_d.cnt = s_q.cnt + 1'b1;
                end
            end else begin
                s_d.pc = s_q.pc + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pc   <= '0;
            s_q.cnt  <= '0;
            s_q.lim  <= LW'(2 * N_MIN - 1);
            s_q.div4 <= 1'b0;
            s_q.stb  <= 1'b0;
            s_q.sq   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign strobe = s_q.stb;
    assign square = s_q.sq;
    assign div4   = s_q.div4;
endmodule

// File: rtl/synth_pfd_lock.sv
module synth_pfd_lock #(
    parameter int LOCK_N = 8,
    parameter int WIDE_N = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_stb,
    input  logic div_stb,
    input  logic ref_tick,
    output logic up,
    output logic dn,
    output logic lock
);
    localparam int WW = $clog2(WIDE_N + 1);
    localparam int GW = $clog2(LOCK_N + 1);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic [WW-1:0] w;
        logic [GW-1:0] good;
        logic          lock;
    } fstate_t;

    fstate_t s_d, s_q;
    logic nu, nd, active, viol;

    always_comb begin
        nu     = s_q.up | ref_stb;
        nd     = s_q.dn | div_stb;
        active = s_q.up | s_q.dn;
        viol   = (s_q.w == WW'(WIDE_N));

        s_d    = s_q;
        s_d.up = nu & ~nd;
        s_d.dn = nd & ~nu;

        if (!active)                                s_d.w = '0;
        else if (ref_tick && s_q.w < WW'(WIDE_N))   s_d.w = s_q.w + 1'b1;

        if (viol) begin
            s_d.good = '0;
            s_d.lock = 1'b0;
        end else begin
            if (ref_stb && s_q.good < GW'(LOCK_N))
                s_d.good = s_q.good + 1'b1;
            s_d.lock = (s_d.good == GW'(LOCK_N));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign up   = s_q.up;
    assign dn   = s_q.dn;
    assign lock = s_q.lock;
endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
    import synth_pkg::*;
#(
    parameter int N_W      = 15,
    parameter int N_MIN    = 1024,
    parameter int R_FINE   = 256,
    parameter int R_MID    = 320,
    parameter int R_COARSE = 512,
    parameter int TH_FINE  = 4096,
    parameter int TH_WIDE  = 8192,
    parameter int LOCK_N   = 8,
    parameter int WIDE_N   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ref_tick,
    input  logic           osc_tick,
    input  logic [N_W-1:0] n_value,
    input  logic           rs_a,
    input  logic           rs_b,
    input  logic           cp_high,
    input  logic           os_off,
    input  logic [2:0]     test_mode,
    output logic           ref_strobe,
    output logic           div_strobe,
    output logic           pump_up,
    output logic           pump_dn,
    output logic           pump_high,
    output logic           amp_off,
    output logic           band_fm_test,
    output logic           band_v_test,
    output logic           presc_div4,
    output logic           lock
);
    logic ref_sq, div_sq, pfd_up, pfd_dn;
    tmode_t    mode;
    pump_out_t out_d;

    synth_ref_div #(
        .R_FINE  (R_FINE),
        .R_MID   (R_MID),
        .R_COARSE(R_COARSE)
    ) u_ref (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ref_tick),
        .rs_a  (rs_a),
        .rs_b  (rs_b),
        .strobe(ref_strobe),
        .square(ref_sq)
    );

    synth_prog_div #(
        .N_W    (N_W),
        .N_MIN  (N_MIN),
        .TH_FINE(TH_FINE),
        .TH_WIDE(TH_WIDE)
    ) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (osc_tick),
        .n_val    (n_value),
        .fine_step(rs_a & rs_b),
        .strobe   (div_strobe),
        .square   (div_sq),
        .div4     (presc_div4)
    );

    synth_pfd_lock #(
        .LOCK_N(LOCK_N),
        .WIDE_N(WIDE_N)
    ) u_pfd (
        .clk     (clk),
        .rst_n   (rst_n),
        .ref_stb (ref_strobe),
        .div_stb (div_strobe),
        .ref_tick(ref_tick),
        .up      (pfd_up),
        .dn      (pfd_dn),
        .lock    (lock)
    );

    always_comb begin
        mode          = tm_decode(test_mode);
        out_d         = '0;
        out_d.hi      = cp_high;
        out_d.fm_test = (mode == TM_REF) & ref_sq;
        out_d.v_test  = (mode == TM_DIV) & div_sq;
        if (os_off) begin
            out_d.dn      = 1'b1;
            out_d.amp_off = 1'b1;
        end else begin
            unique case (mode)
                TM_NORMAL: begin out_d.up = pfd_up; out_d.dn = pfd_dn; end
                TM_SINK:   out_d.dn = 1'b1;
                TM_SOURCE: out_d.up = 1'b1;
                default:   ;
            endcase
        end
    end

    assign pump_up      = out_d.up;
    assign pump_dn      = out_d.dn;
    assign pump_high    = out_d.hi;
    assign amp_off      = out_d.amp_off;
    assign band_fm_test = out_d.fm_test;
    assign band_v_test  = out_d.v_test;
endmodule

// File: rtl/synth_divchain_chk.sv
module synth_divchain_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       os_off,
    input logic [2:0] test_mode,
    input logic       ref_strobe,
    input logic       div_strobe,
    input logic       pump_up,
    input logic       pump_dn,
    input logic       amp_off,
    input logic       presc_div4,
    input logic       lock
);
    logic norm;
    assign norm = (test_mode[2:1] == 2'b00) && !os_off;

    assert_ref_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ref_strobe |=> !ref_strobe);

    assert_presc_at_tc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(presc_div4) |-> div_strobe);

    assert_up_after_ref_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (norm && $past(norm) && $rose(pump_up)) |-> $past(ref_strobe));

    assert_dn_after_div_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (norm && $past(norm) && $rose(pump_dn)) |-> $past(div_strobe));

    assert_no_both_R6: assert property (@(posedge clk) disable iff (!rst_n)
        norm |-> !(pump_up && pump_dn));

    assert_lock_on_ref_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock) |-> $past(ref_strobe));

    assert_os_sink_R10: assert property (@(posedge clk) disable iff (!rst_n)
        os_off |-> (pump_dn && !pump_up && amp_off));
endmodule

bind synth_divchain synth_divchain_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .os_off    (os_off),
    .test_mode (test_mode),
    .ref_strobe(ref_strobe),
    .div_strobe(div_strobe),
    .pump_up   (pump_up),
    .pump_dn   (pump_dn),
    .amp_off   (amp_off),
    .presc_div4(presc_div4),
    .lock      (lock)
);

// File: tb/sim_synth_divchain.sv
`timescale 1ns/1ps
module sim_synth_divchain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b0;
    logic        osc_tick = 1'b1;
    logic [14:0] n_value = '0;
    logic        rs_a = 1'b1, rs_b = 1'b1, cp_high = 1'b0, os_off = 1'b0;
    logic [2:0]  test_mode = 3'b000;
    logic ref_strobe, div_strobe, pump_up, pump_dn, pump_high, amp_off;
    logic band_fm_test, band_v_test, presc_div4, lock;

    int  n_chk = 0, n_fail = 0, ref_k = 16, kc = 0;
    bit  mon_en = 0, saw_up = 0, done = 0;

    always #5 clk = ~clk;

    synth_divchain u0 (.*);

    always @(negedge clk) begin
        ref_tick <= (kc >= ref_k - 1);
        kc       <= (kc >= ref_k - 1) ? 0 : kc + 1;
        if (mon_en && pump_up) saw_up <= 1'b1;
    end

    function automatic int exp_ratio(input bit a, input bit b);
        return b ? (a ? 256 : 512) : 320;
    endfunction
    function automatic int exp_period(input int n);
        return 4 * ((n < 1024) ? 1024 : n);
    endfunction
    function automatic int exp_presc(input int n, input bit a, input bit b);
        int ne = (n < 1024) ? 1024 : n;
        return (ne >= ((a && b) ? 4096 : 8192)) ? 1 : 0;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ref;
        @(negedge clk);
        while (!ref_strobe) @(negedge clk);
    endtask
    task automatic wait_div;
        @(negedge clk);
        while (!div_strobe) @(negedge clk);
    endtask
    task automatic div_interval(output int p);
        p = 0;
        do begin @(negedge clk); p++; end while (!div_strobe);
    endtask
    task automatic ref_interval(output int p);
        p = 0;
        do begin @(negedge clk); p++; end while (!ref_strobe);
    endtask

    initial begin
        repeat (199000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int p, r1, r2, v0, nprev;
        r1 = $urandom(32'h1395);
        r1 = 1024 + ($urandom % 256);
        r2 = 1024 + ($urandom % 256);
        repeat (4) @(negedge clk);
        chk("R11 lock", lock, 0);
        chk("R11 presc", presc_div4, 0);
        chk("R11 up", pump_up, 0);
        chk("R11 dn", pump_dn, 0);
        chk("R11 strobes", ref_strobe | div_strobe, 0);
        rst_n = 1'b1;

        repeat (7) wait_ref;
        chk("R7 no early lock", lock, 0);
        wait_ref;
        @(negedge clk);
        chk("R7 lock after 8", lock, 1);

        wait_div;
        div_interval(p);
        chk("R2 clamp N=0", p, exp_period(0));
        n_value = 15'd4095;
        div_interval(p);
        chk("R5 old interval kept", p, exp_period(0));
        mon_en = 1;
        div_interval(p);
        chk("R2 N=4095", p, exp_period(4095));
        chk("R3 4095 fine", presc_div4, exp_presc(4095, 1, 1));
        chk("R8 lock lost", lock, 0);
        chk("R6 up seen when ref leads", saw_up, 1);
        n_value = 15'd4096;
        div_interval(p);
        chk("R5 old 4095", p, exp_period(4095));
        chk("R3 4096 fine", presc_div4, exp_presc(4096, 1, 1));
        rs_b = 1'b0; n_value = 15'd8191;
        div_interval(p);
        chk("R4 4096 via div4", p, exp_period(4096));
        chk("R3 8191 wide", presc_div4, exp_presc(8191, 1, 0));
        n_value = 15'd8192;
        div_interval(p);
        chk("R4 8191 via div2", p, exp_period(8191));
        chk("R3 8192 wide", presc_div4, exp_presc(8192, 1, 0));
        n_value = 15'(r1);
        div_interval(p);
        chk("R4 8192 via div4", p, exp_period(8192));
        chk("R3 random", presc_div4, exp_presc(r1, 1, 0));
        n_value = 15'(r2);
        div_interval(p);
        chk("R2 random 1", p, exp_period(r1));
        div_interval(p);
        chk("R2 random 2", p, exp_period(r2));

        ref_k = 1;
        wait_ref; wait_ref;
        ref_interval(p);
        chk("R1 ratio a1 b0", p, exp_ratio(1, 0));
        rs_a = 1; rs_b = 1;
        wait_ref; ref_interval(p);
        chk("R1 ratio a1 b1", p, exp_ratio(1, 1));
        rs_a = 0;
        wait_ref; ref_interval(p);
        chk("R1 ratio a0 b1", p, exp_ratio(0, 1));
        rs_b = 0;
        wait_ref; ref_interval(p);
        chk("R1 ratio a0 b0", p, exp_ratio(0, 0));

        @(negedge clk); cp_high = 1; #1;
        chk("R10 pump high", pump_high, 1);
        os_off = 1; test_mode = 3'b011; #1;
        chk("R10 os dn", pump_dn, 1);
        chk("R10 os up", pump_up, 0);
        chk("R10 amp off", amp_off, 1);
        os_off = 0; test_mode = 3'b010; #1;
        chk("R9 off", {pump_up, pump_dn}, 0);
        test_mode = 3'b110; #1;
        chk("R9 sink", {pump_up, pump_dn}, 1);
        test_mode = 3'b011; #1;
        chk("R9 source", {pump_up, pump_dn}, 2);
        test_mode = 3'b111; #1;
        chk("R9 mode 111 off", {pump_up, pump_dn}, 0);
        test_mode = 3'b100; #1;
        v0 = band_fm_test;
        wait_ref;
        chk("R9 ref toggles", (band_fm_test != v0) ? 1 : 0, 1);
        chk("R9 v pin idle", band_v_test, 0);
        test_mode = 3'b101; #1;
        v0 = band_v_test;
        wait_div;
        chk("R9 div toggles", (band_v_test != v0) ? 1 : 0, 1);
        chk("R9 fm pin idle", band_fm_test, 0);
        nprev = band_v_test;
        wait_div;
        chk("R9 div toggles again", (band_v_test != nprev) ? 1 : 0, 1);
        test_mode = 3'b000; #1;
        chk("R9 normal pins idle", {band_fm_test, band_v_test}, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule